// File: doc/BRIEF.md
# Nine-bit serial link engine

This block drives a display controller over a three-wire serial link whose words are nine bits long. The most significant bit of every outgoing word tells the controller whether the remaining eight bits are a command or a parameter. The host side hands over one request at a time, made of a byte and a kind code. The engine turns it into a chip-select framed word on the link and reports completion with a one-cycle pulse. A full command write is therefore one command request followed by zero or more parameter requests.

A third kind of request fetches the controller's identification byte. The engine sends a fixed nine-bit read opcode. It then runs a nine-clock dummy word whose input bits are thrown away, and finally runs an eight-clock word whose input bits become the returned byte. The serial clock idles low and the slave samples on its rising edge. The half-period in system clocks is derived from two frequency parameters.

Top module: `s9_link`

## Requirements
- R1: After reset, and whenever reset is asserted, spi_cs_n is 1, spi_sclk is 0, spi_sdo is 0, req_ready is 1, and done and err are 0.
- R2: A request with req_kind 0 (command) produces exactly one chip-select frame of 9 clocks whose bits, most significant first, are 0 followed by req_byte.
- R3: A request with req_kind 1 (parameter) produces exactly one frame of 9 clocks whose bits, most significant first, are 1 followed by req_byte.
- R4: spi_sclk is 0 whenever spi_cs_n changes. spi_sclk rises only while spi_cs_n is 0. spi_sdo holds its value while spi_sclk is high, so it changes only on or after a falling edge.
- R5: Each high phase and each low phase of spi_sclk inside a frame lasts HALF = SYS_CLK_HZ / (2*SCLK_HZ) system clocks.
- R6: spi_cs_n is 0 for the duration of each word and returns to 1 between words, staying high for at least HALF system clocks between the frames of one request.
- R7: A request with req_kind 2 (ID read) produces three frames. The first is 9 clocks carrying 0x004. The second is 9 clocks with spi_sdo held 0, and its sampled input is discarded. The third is 8 clocks, and the bits spi_sdi holds at its rising edges, most significant first, become rd_byte.
- R8: done pulses for exactly one cycle after the last frame of each accepted kind 0, 1 or 2 request. For an ID read, rd_byte carries the new value in that same cycle.
- R9: req_ready is 0 from the cycle after a request is accepted until done. A req_valid seen while req_ready is 0 starts no frame.
- R10: A request with req_kind 3 raises err for one cycle in the cycle after acceptance. It starts no frame, raises no done, and leaves req_ready at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 command, 1 parameter, 2 ID read, 3 illegal |
| req_byte | input | DATA_W | Byte to send for kinds 0 and 1 |
| req_ready | output | 1 | Engine idle, request will be accepted |
| spi_cs_n | output | 1 | Chip select, active low, one frame per word |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data to the controller |
| spi_sdi | input | 1 | Serial data from the controller |
| rd_byte | output | DATA_W | Last identification byte read |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an illegal kind |

## Verification
The hardest situation to reach from the ports is an ID read, where the returned value depends on the alignment between the dummy word and the result word. If the engine samples one edge early or late, or keeps dummy bits, the captured byte shifts. The bench models the controller as a serial slave that presents a seventeen-bit stream, made of nine dummy bits and then the ID byte. This stream advances only on falling clock edges after the opcode frame. Dummy patterns that differ from the ID, including all ones, make any misalignment show up in rd_byte.

// File: rtl/s9_pkg.sv
package s9_pkg;
   typedef enum logic [1:0] {
      KIND_CMD   = 2'd0,
      KIND_PARAM = 2'd1,
      KIND_IDRD  = 2'd2,
      KIND_BAD   = 2'd3
   } s9_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_GAP  = 2'd3
   } s9_phase_e;
endpackage

// File: rtl/s9_tick.sv
module s9_tick #(
   parameter int HALF = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (cnt == CW'(HALF - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = run && (cnt == CW'(HALF - 1));
      end
   endgenerate
endmodule

// File: rtl/s9_shifter.sv
module s9_shifter
   import s9_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int WORD_W = DATA_W + 1,
   localparam int LW = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LW-1:0]     len,
   input  logic [WORD_W-1:0] tx,
   input  logic              tick,
   input  logic              sdi,
   output logic              cs_n,
   output logic              sclk,
   output logic              sdo,
   output logic [DATA_W-1:0] rx,
   output logic              run,
   output logic              word_done
);
   s9_phase_e         phase;
   logic [WORD_W-1:0] shreg;
   logic [LW-1:0]     left;

   assign run = (phase != PH_IDLE);
   assign sdo = shreg[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         shreg     <= '0;
         left      <= '0;
         cs_n      <= 1'b1;
         sclk      <= 1'b0;
         rx        <= '0;
         word_done <= 1'b0;
      end else begin
         word_done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase <= PH_LOW;
                  shreg <= tx;
                  left  <= len;
                  cs_n  <= 1'b0;
               end
            end
            PH_LOW: begin
               if (tick) begin
                  sclk  <= 1'b1;
                  rx    <= {rx[DATA_W-2:0], sdi};
                  phase <= PH_HIGH;
               end
            end
            PH_HIGH: begin
               if (tick) begin
                  sclk <= 1'b0;
                  if (left == LW'(1)) begin
                     phase <= PH_GAP;
                     cs_n  <= 1'b1;
                     shreg <= '0;
                  end else begin
                     left  <= left - 1'b1;
                     shreg <= {shreg[WORD_W-2:0], 1'b0};
                     phase <= PH_LOW;
                  end
               end
            end
            default: begin
               if (tick) begin
                  phase     <= PH_IDLE;
                  word_done <= 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/s9_link.sv
module s9_link
   import s9_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int SCLK_HZ    = 1_000_000,
   parameter int DATA_W     = 8,
   parameter int ID_OPCODE  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [DATA_W-1:0] req_byte,
   output logic              req_ready,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_sdo,
   input  logic              spi_sdi,
   output logic [DATA_W-1:0] rd_byte,
   output logic              done,
   output logic              err
);
   localparam int HALF   = SYS_CLK_HZ / (2 * SCLK_HZ);
   localparam int WORD_W = DATA_W + 1;
   localparam int LW     = $clog2(WORD_W + 1);

   generate
      if (HALF < 1) begin : g_bad_rate
         $error("s9_link: SCLK_HZ too high for SYS_CLK_HZ");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("s9_link: DATA_W must be at least 2");
      end
      if (ID_OPCODE < 0 || ID_OPCODE >= (1 << WORD_W)) begin : g_bad_op
         $error("s9_link: ID_OPCODE does not fit a word");
      end
   endgenerate

   logic              busy;
   logic              is_rd;
   logic [1:0]        step;
   logic              start;
   logic [WORD_W-1:0] tx;
   logic [LW-1:0]     len;
   logic              tick;
   logic              run;
   logic              word_done;
   logic [DATA_W-1:0] rx;

   assign req_ready = !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         is_rd   <= 1'b0;
         step    <= '0;
         start   <= 1'b0;
         tx      <= '0;
         len     <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         rd_byte <= '0;
      end else begin
         start <= 1'b0;
         done  <= 1'b0;
         err   <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               step <= '0;
               len  <= LW'(WORD_W);
               case (s9_kind_e'(req_kind))
                  KIND_CMD, KIND_PARAM: begin
                     tx    <= {req_kind == KIND_PARAM, req_byte};
                     is_rd <= 1'b0;
                     busy  <= 1'b1;
                     start <= 1'b1;
                  end
                  KIND_IDRD: begin
                     tx    <= WORD_W'(ID_OPCODE);
                     is_rd <= 1'b1;
                     busy  <= 1'b1;
                     start <= 1'b1;
                  end
                  default: begin
                     err <= 1'b1;
                  end
               endcase
            end
         end else if (word_done) begin
            if (!is_rd || step == 2'd2) begin
               busy <= 1'b0;
               done <= 1'b1;
               if (is_rd) begin
                  rd_byte <= rx;
               end
            end else begin
               step  <= step + 1'b1;
               start <= 1'b1;
               tx    <= '0;
               len   <= (step == 2'd0) ? LW'(WORD_W) : LW'(DATA_W);
            end
         end
      end
   end

   s9_tick #(.HALF(HALF)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .tick (tick)
   );

   s9_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len      (len),
      .tx       (tx),
      .tick     (tick),
      .sdi      (spi_sdi),
      .cs_n     (spi_cs_n),
      .sclk     (spi_sclk),
      .sdo      (spi_sdo),
      .rx       (rx),
      .run      (run),
      .word_done(word_done)
   );
endmodule

// File: rtl/s9_link_chk.sv
module s9_link_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_kind,
   input logic       req_ready,
   input logic       spi_cs_n,
   input logic       spi_sclk,
   input logic       spi_sdo,
   input logic       done,
   input logic       err
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (spi_cs_n && !spi_sclk));

   assert_rise_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> !spi_cs_n);

   assert_sdo_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_sdo));

   assert_cs_edge_low_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !spi_sclk);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_kind != 2'd3) |=> !req_ready);

   assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(req_valid && req_ready && req_kind == 2'd3));

   assert_err_no_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(err && done));
endmodule

bind s9_link s9_link_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_kind (req_kind),
   .req_ready(req_ready),
   .spi_cs_n (spi_cs_n),
   .spi_sclk (spi_sclk),
   .spi_sdo  (spi_sdo),
   .done     (done),
   .err      (err)
);

// File: tb/s9_link_bench.sv
module s9_link_bench;
   localparam int SYS  = 50_000_000;
   localparam int SCK  = 5_000_000;
   localparam int HALF = SYS / (2 * SCK);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_kind = 2'd0;
   logic [7:0] req_byte = 8'd0;
   logic       req_ready, spi_cs_n, spi_sclk, spi_sdo, spi_sdi, done, err;
   logic [7:0] rd_byte;

   always #10 clk = ~clk;

   s9_link #(.SYS_CLK_HZ(SYS), .SCLK_HZ(SCK)) u_s9_link (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_byte(req_byte), .req_ready(req_ready), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_sdo(spi_sdo), .spi_sdi(spi_sdi),
      .rd_byte(rd_byte), .done(done), .err(err)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;

   // slave model and link monitor
   logic [16:0] sl_bits = '0;
   logic        id_mode = 1'b0;
   int          frame_cnt = 0;
   logic [8:0]  mon_w = '0;
   int          mon_n = 0;
   logic [8:0]  fw [4];
   int          fn [4];
   int          hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0;
   int          cs_hi_run = 0, min_gap = 1000;
   int          sdo_glitch = 0;
   logic        prev_sclk = 1'b0, prev_sdo = 1'b0;
   int          done_seen = 0;

   assign spi_sdi = sl_bits[16];

   always @(negedge spi_sclk) if (id_mode && frame_cnt >= 1) sl_bits = sl_bits << 1;
   always @(posedge spi_sclk) if (!spi_cs_n) begin
      mon_w = {mon_w[7:0], spi_sdo};
      mon_n = mon_n + 1;
   end
   always @(negedge spi_cs_n) begin mon_w = '0; mon_n = 0; end
   always @(posedge spi_cs_n) begin
      if (frame_cnt < 4) begin fw[frame_cnt] = mon_w; fn[frame_cnt] = mon_n; end
      frame_cnt = frame_cnt + 1;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_sclk) hi_run = hi_run + 1;
         else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
         if (!spi_sclk && !spi_cs_n) lo_run = lo_run + 1;
         else if (lo_run != 0) begin last_lo = lo_run; lo_run = 0; end
         if (spi_cs_n) cs_hi_run = cs_hi_run + 1;
         else if (cs_hi_run != 0) begin
            if (id_mode && frame_cnt >= 1 && cs_hi_run < min_gap) min_gap = cs_hi_run;
            cs_hi_run = 0;
         end
         if (spi_sclk && prev_sclk && spi_sdo != prev_sdo) sdo_glitch = sdo_glitch + 1;
         if (done) done_seen = done_seen + 1;
      end
      prev_sclk = spi_sclk;
      prev_sdo  = spi_sdo;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_vec = n_vec + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] k, input logic [7:0] b);
      for (int i = 0; i < 5000 && !req_ready; i++) @(negedge clk);
      frame_cnt = 0;
      done_seen = 0;
      req_valid = 1'b1; req_kind = k; req_byte = b;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done(output bit got);
      got = 1'b0;
      for (int i = 0; i < 5000 && !got; i++) begin
         if (done) got = 1'b1;
         else @(negedge clk);
      end
   endtask

   // kind, byte, expected 9-bit frame
   localparam logic [18:0] VEC [8] = '{
      {2'd0, 8'h36, 9'h036}, {2'd1, 8'h08, 9'h108},
      {2'd0, 8'h11, 9'h011}, {2'd1, 8'hFF, 9'h1FF},
      {2'd1, 8'h00, 9'h100}, {2'd0, 8'hB6, 9'h0B6},
      {2'd1, 8'hA5, 9'h1A5}, {2'd0, 8'h29, 9'h029}
   };

   task automatic id_read(input logic [8:0] dummy, input logic [7:0] id);
      bit got;
      sl_bits = {dummy, id};
      id_mode = 1'b1;
      min_gap = 1000;
      send(2'd2, 8'h00);
      wait_done(got);
      check(got, "R8 id done", int'(got), 1);
      check(rd_byte == id, "R7 id byte", rd_byte, id);
      check(frame_cnt == 3, "R7 frame count", frame_cnt, 3);
      check(fw[0] == 9'h004 && fn[0] == 9, "R7 opcode frame", fw[0], 9'h004);
      check(fw[1] == 9'h000 && fn[1] == 9, "R7 dummy frame", fn[1], 9);
      check(fn[2] == 8, "R7 result frame length", fn[2], 8);
      check(min_gap >= HALF, "R6 gap between words", min_gap, HALF);
      @(negedge clk);
      check(!done, "R8 done one cycle", done, 0);
      id_mode = 1'b0;
   endtask

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      bit got;
      repeat (3) @(negedge clk);
      check(spi_cs_n && !spi_sclk && !spi_sdo && req_ready && !done && !err,
            "R1 reset state", {spi_cs_n, spi_sclk, spi_sdo, req_ready, done, err}, 6'b100100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < 8; v++) begin
         send(VEC[v][18:17], VEC[v][16:9]);
         check(!req_ready, "R9 busy after accept", req_ready, 0);
         wait_done(got);
         check(got && frame_cnt == 1 && fn[0] == 9 && fw[0] == VEC[v][8:0],
               VEC[v][18:17] == 2'd0 ? "R2 command frame" : "R3 parameter frame",
               fw[0], VEC[v][8:0]);
      end
      check(last_hi == HALF, "R5 sclk high phase", last_hi, HALF);
      check(last_lo == HALF, "R5 sclk low phase", last_lo, HALF);

      id_read(9'h1B3, 8'h80);
      id_read(9'h1FF, 8'h5C);
      id_read(9'h000, 8'hA3);

      // R9: a request while busy is ignored
      send(2'd0, 8'h3A);
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_kind = 2'd1; req_byte = 8'hAA;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(got);
      repeat (4 * HALF + 10) @(negedge clk);
      check(frame_cnt == 1 && fw[0] == 9'h03A, "R9 busy request ignored", frame_cnt, 1);
      check(done_seen == 1, "R9 single completion", done_seen, 1);

      // R10: illegal kind
      for (int i = 0; i < 5000 && !req_ready; i++) @(negedge clk);
      frame_cnt = 0; done_seen = 0;
      req_valid = 1'b1; req_kind = 2'd3; req_byte = 8'h55;
      @(negedge clk);
      req_valid = 1'b0;
      check(err && req_ready, "R10 err pulse", {err, req_ready}, 2'b11);
      @(negedge clk);
      check(!err, "R10 err one cycle", err, 0);
      repeat (100) @(negedge clk);
      check(frame_cnt == 0 && done_seen == 0, "R10 no frame no done", frame_cnt, 0);

      check(sdo_glitch == 0, "R4 sdo stable while sclk high", sdo_glitch, 0);

      // R1: reset in the middle of a transfer
      send(2'd1, 8'hC3);
      repeat (3 * HALF) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(spi_cs_n && !spi_sclk && !spi_sdo && req_ready && !done,
            "R1 reset mid transfer", {spi_cs_n, spi_sclk, spi_sdo, req_ready}, 4'b1001);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      send(2'd0, 8'h5E);
      wait_done(got);
      check(got && fw[0] == 9'h05E && fn[0] == 9, "R2 frame after reset", fw[0], 9'h05E);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule